// File: doc/BRIEF.md
# Dual-Buffer Frame Transmit Controller

This block holds two transmit packet buffers behind a 32-bit register port. Each buffer has a data area, a frame-length register and a command register. One shared interrupt-enable register sits only in the address window of buffer 0. Software fills a buffer and sets its length. It then writes a command word that does one of two things. The first option sends the frame out as a byte stream with valid, ready and last. The second option takes the first six bytes of the buffer and uses them as the station address, which goes to a receive address filter.

A single engine runs the commands. If both buffers have a command waiting when the engine is free, buffer 0 goes first. While a command is in progress, its command bits read back as set and the buffer accepts no new command. When the command finishes, those bits clear. The block can then raise a one-cycle interrupt pulse if both the buffer's own enable and the shared enable allow it.

Top module: `txbuf_ctrl`

## Requirements
- R1: Byte offsets within each 0x800-byte buffer window are fixed. Data words are at 0x000–0x7F0, length is at 0x7F4 (bits 15:0), the shared enable is at 0x7F8 (bit 31, buffer 0 only) and the command is at 0x7FC (bits 3, 1, 0). Bit 11 of the address selects buffer 1. Reads return the stored value one cycle after the access, and bits that are not implemented read 0.
- R2: A command write with bit 0 = 1 and bit 1 = 0 sends `length` bytes in buffer order. Byte i is taken from data word i/4, bits [8*(i%4)+7 : 8*(i%4)]. `tx_last` is high only on byte length−1.
- R3: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R4: A transmit command with length 0, or with a length above 2036, completes without sending any bytes. A length of exactly 2036 sends the whole data area.
- R5: A command write with bits 1 and 0 both set sends no bytes. It loads `station_mac` with buffer byte 0 in bits 47:40 down to byte 5 in bits 7:0.
- R6: Command bits 1:0 read back as written while the command is in progress and clear when it completes. A command write with bit 0 = 0 stores bits 1:0 as 0 and starts nothing.
- R7: A command write to a buffer whose command is still in progress has no effect on its register, its output stream or `station_mac`.
- R8: On completion, `irq` pulses high for one cycle only if the buffer's command bit 3 and shared-enable bit 31 are both set. Offset 0xFF8 reads 0 and a write to it has no effect.
- R9: After reset, no byte is offered, `irq` is low, `station_mac` is 0 and all registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | Byte available |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Sink accepts the byte |
| irq | output | 1 | Completion interrupt pulse |
| station_mac | output | 48 | Station address for receive filtering |

## Verification
Some rules can be checked on every cycle, and the assertions cover these. A stalled byte stream must hold steady. `tx_last` must never appear without `tx_valid`. The interrupt must be a single-cycle pulse that the shared enable allows. The station address must not change while a frame is streaming. Other behaviour can only be shown by the bench's scenarios: byte order and length, lengths that are empty or too large, loading the address, busy readback, ignored writes, and the per-buffer interrupt gating. In these scenarios a scoreboard compares every streamed byte with the frames the driver loaded.

// File: rtl/txbuf_ctrl.sv
module txbuf_ctrl #(
  parameter int BUF_WORDS = 512,
  parameter int LEN_W     = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_sel,
  input  logic                            bus_wr,
  input  logic [$clog2(BUF_WORDS)+2:0]    bus_addr,
  input  logic [31:0]                     bus_wdata,
  output logic [31:0]                     bus_rdata,
  output logic [7:0]                      tx_data,
  output logic                            tx_valid,
  output logic                            tx_last,
  input  logic                            tx_ready,
  output logic                            irq,
  output logic [47:0]                     station_mac
);
  localparam int IDX_W      = $clog2(BUF_WORDS);
  localparam int DATA_WORDS = BUF_WORDS - 3;
  localparam int DATA_BYTES = DATA_WORDS * 4;
  localparam logic [IDX_W-1:0] LEN_OFS = IDX_W'(BUF_WORDS - 3);
  localparam logic [IDX_W-1:0] GIE_OFS = IDX_W'(BUF_WORDS - 2);
  localparam logic [IDX_W-1:0] CTL_OFS = IDX_W'(BUF_WORDS - 1);

  typedef enum logic [1:0] {IDLE, STREAM, DONE} st_t;

  logic [31:0]      mem [0:2*BUF_WORDS-1];
  logic [LEN_W-1:0] len_q [2];
  logic [3:0]       ctl_q [2];
  logic             gie_q;
  st_t              st;
  logic             cur;
  logic [LEN_W-1:0] cnt, tlen;

  wire             wr     = bus_sel & bus_wr;
  wire             a_buf  = bus_addr[IDX_W+2];
  wire [IDX_W-1:0] a_idx  = bus_addr[IDX_W+1:2];
  wire [1:0]       busy   = {ctl_q[1][0], ctl_q[0][0]};
  wire             pick   = (st == IDLE) && (busy != 2'b00);
  wire             pbuf   = ~busy[0];
  wire [31:0]      w0     = mem[{pbuf, {IDX_W{1'b0}}}];
  wire [31:0]      w1     = mem[{pbuf, IDX_W'(1)}];
  wire [31:0]      tword  = mem[{cur, cnt[IDX_W+1:2]}];

  assign tx_valid = (st == STREAM);
  assign tx_last  = tx_valid && (cnt == tlen - 1'b1);
  assign tx_data  = tword[{cnt[1:0], 3'b000} +: 8];

  always_ff @(posedge clk) begin
    if (wr && a_idx < IDX_W'(DATA_WORDS)) mem[{a_buf, a_idx}] <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q[0] <= '0;
      len_q[1] <= '0;
      ctl_q[0] <= '0;
      ctl_q[1] <= '0;
      gie_q    <= 1'b0;
    end else begin
      if (wr && !a_buf && a_idx == GIE_OFS) gie_q <= bus_wdata[31];
      for (int b = 0; b < 2; b++) begin
        if (wr && a_buf == 1'(b) && a_idx == LEN_OFS) len_q[b] <= bus_wdata[LEN_W-1:0];
        if (wr && a_buf == 1'(b) && a_idx == CTL_OFS && !busy[b])
          ctl_q[b] <= {bus_wdata[3], 1'b0, bus_wdata[1] & bus_wdata[0], bus_wdata[0]};
        if (st == DONE && cur == 1'(b)) ctl_q[b][1:0] <= 2'b00;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= IDLE;
      cur         <= 1'b0;
      cnt         <= '0;
      tlen        <= '0;
      irq         <= 1'b0;
      station_mac <= '0;
    end else begin
      irq <= 1'b0;
      case (st)
        IDLE: if (pick) begin
          cur  <= pbuf;
          cnt  <= '0;
          tlen <= len_q[pbuf];
          if (ctl_q[pbuf][1]) begin
            station_mac <= {w0[7:0], w0[15:8], w0[23:16], w0[31:24], w1[7:0], w1[15:8]};
            st <= DONE;
          end else if (len_q[pbuf] == '0 || 32'(len_q[pbuf]) > DATA_BYTES) begin
            st <= DONE;
          end else begin
            st <= STREAM;
          end
        end
        STREAM: if (tx_ready) begin
          if (tx_last) st <= DONE;
          else cnt <= cnt + 1'b1;
        end
        default: begin
          irq <= ctl_q[cur][3] & gie_q;
          st  <= IDLE;
        end
      endcase
    end
  end

  logic [31:0] rd_val;
  always_comb begin
    case (a_idx)
      LEN_OFS: rd_val = 32'(len_q[a_buf]);
      GIE_OFS: rd_val = a_buf ? 32'h0 : {gie_q, 31'h0};
      CTL_OFS: rd_val = {28'h0, ctl_q[a_buf]};
      default: rd_val = mem[{a_buf, a_idx}];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_sel && !bus_wr) bus_rdata <= rd_val;
  end
endmodule

// File: rtl/txbuf_ctrl_chk.sv
module txbuf_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic        tx_last,
  input logic [7:0]  tx_data,
  input logic        irq,
  input logic        gie_en,
  input logic [47:0] station_mac
);
  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));
  // R2
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);
  // R8
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(gie_en));
  // R5
  mac_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> $stable(station_mac));
endmodule

bind txbuf_ctrl txbuf_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_last(tx_last), .tx_data(tx_data), .irq(irq), .gie_en(gie_q),
  .station_mac(station_mac)
);

// File: tb/tb_txbuf_ctrl.sv
module tb_txbuf_ctrl;
  logic        clk = 0, rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_last, tx_ready = 0, irq;
  logic [47:0] station_mac;

  int checks = 0, errors = 0, irqs = 0;
  bit hold_ready = 0, done = 0;
  logic [8:0] exp_q[$];

  txbuf_ctrl dut (.*);

  always #4 clk = ~clk;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (irq) irqs++;
    tx_ready = hold_ready ? 1'b0 : ($urandom % 4 != 0);
    if (rst_n && tx_valid && tx_ready) begin
      if (exp_q.size() == 0) chk(0, "R2 unexpected byte", {tx_last, tx_data}, 0);
      else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk({tx_last, tx_data} == e, "R2 stream byte/last", {tx_last, tx_data}, e);
      end
    end
  end

  task automatic bw(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic br(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  function automatic logic [7:0] pat(int seed, int i);
    return 8'(seed + i * 7);
  endfunction

  task automatic load(bit b, int n, int seed);
    for (int w = 0; w < (n + 3) / 4; w++)
      bw({b, 11'(w * 4)}, {pat(seed, 4*w+3), pat(seed, 4*w+2), pat(seed, 4*w+1), pat(seed, 4*w)});
  endtask

  task automatic send(bit b, int n, bit ie, int seed);
    load(b, n, seed);
    bw({b, 11'h7F4}, 32'(n));
    for (int i = 0; i < n && n <= 2036; i++) exp_q.push_back({i == n - 1, pat(seed, i)});
    bw({b, 11'h7FC}, {28'h0, ie, 3'b001});
  endtask

  task automatic wait_idle(bit b);
    logic [31:0] d;
    for (int k = 0; k < 20000; k++) begin
      br({b, 11'h7FC}, d);
      if (d[1:0] == 2'b00) break;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    chk(0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9
    chk(!tx_valid && !irq, "R9 outputs idle", {tx_valid, irq}, 0);
    chk(station_mac == 0, "R9 mac zero", station_mac, 0);
    br(12'h7FC, d); chk(d == 0, "R9 ctrl0 zero", d, 0);
    br(12'hFF4, d); chk(d == 0, "R9 len1 zero", d, 0);
    // R1
    bw(12'h7F8, 32'hFFFF_FFFF); br(12'h7F8, d); chk(d == 32'h8000_0000, "R1 gie readback", d, 32'h8000_0000);
    bw(12'h7F4, 32'h0001_2345); br(12'h7F4, d); chk(d == 32'h2345, "R1 len readback", d, 32'h2345);
    bw(12'h810, 32'hCAFE_F00D); br(12'h810, d); chk(d == 32'hCAFE_F00D, "R1 data readback", d, 32'hCAFE_F00D);
    // R8
    bw(12'hFF8, 32'h8000_0000); br(12'hFF8, d); chk(d == 0, "R8 0xFF8 reads 0", d, 0);
    // R2 R8
    base = irqs;
    send(0, 7, 1, 3); wait_idle(0);
    chk(irqs == base + 1, "R8 irq with both enables", irqs - base, 1);
    chk(exp_q.size() == 0, "R2 seven byte frame", exp_q.size(), 0);
    base = irqs;
    send(1, 64, 0, 90); wait_idle(1);
    chk(irqs == base, "R8 no irq without buffer enable", irqs - base, 0);
    chk(exp_q.size() == 0, "R3 stalled 64 byte frame", exp_q.size(), 0);
    send(0, 1, 1, 200); wait_idle(0);
    chk(exp_q.size() == 0, "R2 single byte frame", exp_q.size(), 0);
    // R6 R7
    hold_ready = 1;
    send(0, 5, 1, 17);
    repeat (4) @(negedge clk);
    br(12'h7FC, d); chk(d == 32'h9, "R6 busy readback", d, 32'h9);
    bw(12'h7FC, 32'hB); br(12'h7FC, d); chk(d == 32'h9, "R7 busy write ignored", d, 32'h9);
    hold_ready = 0;
    wait_idle(0);
    br(12'h7FC, d); chk(d == 32'h8, "R6 bits cleared", d, 32'h8);
    chk(station_mac == 0, "R7 mac untouched", station_mac, 0);
    chk(exp_q.size() == 0, "R7 one frame only", exp_q.size(), 0);
    // R4
    bw(12'h7F4, 0); bw(12'h7FC, 32'h1); wait_idle(0);
    br(12'h7FC, d); chk(d == 0, "R4 zero length completes", d, 0);
    bw(12'h7F4, 2037); bw(12'h7FC, 32'h1); wait_idle(0);
    br(12'h7FC, d); chk(d == 0, "R4 oversize completes", d, 0);
    send(1, 2036, 0, 5); wait_idle(1);
    chk(exp_q.size() == 0, "R4 full 2036 byte frame", exp_q.size(), 0);
    // R5
    base = irqs;
    bw(12'h800, 32'h3322_1102); bw(12'h804, 32'h0000_5544);
    bw(12'hFFC, 32'hB); wait_idle(1);
    chk(station_mac == 48'h0211_2233_4455, "R5 mac load", station_mac, 48'h0211_2233_4455);
    chk(irqs == base + 1, "R8 irq on mac load", irqs - base, 1);
    // R8
    base = irqs;
    bw(12'h7F8, 0); bw(12'hFF8, 32'h8000_0000);
    send(1, 3, 1, 66); wait_idle(1);
    chk(irqs == base, "R8 gie off, 0xFF8 no effect", irqs - base, 0);
    // R6
    bw(12'h7FC, 32'h2); br(12'h7FC, d); chk(d == 0, "R6 program alone stores nothing", d, 0);
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0 && !tx_valid, "R6 program alone starts nothing", tx_valid, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule